// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Read Cache

This block is a small direct-mapped data cache on the load path of a core. A request carries a virtual address. On the cycle it is accepted, the cache reads the indexed line from its tag and data stores using bits of that virtual address. In the same cycle it sends the virtual page number to an external translation unit. When the translation unit returns a physical page number, the cache compares that number with the stored tag. The cost of translation is therefore hidden behind the array read instead of being added in front of it.

The index and the line offset both lie inside the page offset. With the defaults (4 KiB pages, 64 lines of 64 bytes) they fill it exactly. The index is therefore the same whether it is taken from the virtual or the physical address. Two virtual pages that map to one physical page meet in the same line, and a change of address space needs no flush: a stale mapping simply fails the physical tag compare. A miss fetches the whole line from memory by its physical line address, installs it with its tag, and returns the requested word.

Handshakes:
- Requests and responses use valid/ready. A request moves when `req_valid` and `req_ready` are both high on a rising edge. `req_ready` is high only when nothing is outstanding.
- A response holds `rsp_valid`, `rsp_data` and `rsp_hit` unchanged until `rsp_ready` is seen high.
- The refill request holds `mem_req_valid` and its address until `mem_req_ready`.
- The refill line is taken on any edge where `mem_rsp_valid` and `mem_rsp_ready` are both high.
- The translation port is plain: `xl_req` is a one-cycle pulse. The answer must arrive at least one cycle later as `xl_valid` with `xl_ppn`. `xl_miss` marks cycles in which the translation is still being resolved.

Top module: `vipt_cache`

## Requirements
- R1: After reset every line is invalid, so the first access to any line reports a miss. `req_ready` is high and `rsp_valid`, `mem_req_valid` and `xl_req` are low while no request is offered.
- R2: In the cycle a request is accepted, `xl_req` is high and `xl_vpn` equals the upper `VA_W-PAGE_OFF_W` bits of `req_vaddr`; no wait on translation precedes the array read.
- R3: When the indexed line is valid and its stored tag equals the returned physical page, the response has `rsp_hit`=1, carries the stored word, and no refill request is made.
- R4: Otherwise one refill request is issued with address {physical page, `req_vaddr[PAGE_OFF_W-1:OFF_W]`}. The returned line and its tag are installed, and the response has `rsp_hit`=0 and carries the requested word of the returned line.
- R5: While `xl_valid` is low or `xl_miss` is high, the request stays pending: no response, no refill request, and `req_ready` low.
- R6: At most one request is outstanding. `req_ready` is low from acceptance until the response handshake, and high again in the following cycle.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data` and `rsp_hit` keep their values.
- R8: A line is identified only by its physical tag. A second virtual page mapped to the same physical page hits on the line the first one filled. Remapping a virtual page to a new physical page makes the next access miss, without any flush.
- R9: `rsp_data` is word `req_vaddr[OFF_W-1:2]` of the line, with word 0 in bits [31:0] of the line bus.
- R10: The cache is direct-mapped. Two physical lines with the same index replace each other, so alternating between them misses every time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request offered |
| req_ready | output | 1 | Cache idle and accepting |
| req_vaddr | input | VA_W | Virtual byte address |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Requester takes response |
| rsp_data | output | WORD_W | Requested word |
| rsp_hit | output | 1 | 1 = served from the array, 0 = refilled |
| xl_req | output | 1 | Translation request pulse |
| xl_vpn | output | VA_W-PAGE_OFF_W | Virtual page number to translate |
| xl_valid | input | 1 | Translation result valid |
| xl_miss | input | 1 | Translation still being resolved |
| xl_ppn | input | PA_W-PAGE_OFF_W | Physical page number |
| mem_req_valid | output | 1 | Line refill request |
| mem_req_ready | input | 1 | Memory accepts refill request |
| mem_req_addr | output | PA_W-OFF_W | Physical line address |
| mem_rsp_valid | input | 1 | Refill line returned |
| mem_rsp_ready | output | 1 | Cache waiting for refill line |
| mem_rsp_data | input | LINE_BYTES*8 | Refill line, word 0 in low bits |

## Verification
The access sequence is built to separate the cases the tag compare has to decide:
- A cold line, a warm line reached through a second word, and an aliasing virtual page show that hits depend on the physical tag and not on the virtual page.
- Two physical pages sharing one index, accessed in turn, expose direct-mapped replacement.
- A remapped page shows that a stale translation misses without any flush.

Translation latency is varied from one to four cycles, so extra cycles appear as `xl_miss`, and memory latency is varied as well. This separates a cache that waits for the translation from one that compares too early. Distinct refill contents per line and per word catch wrong word selection or a wrong line address. A response held against a low `rsp_ready`, and a reset given in the middle of the run, cover holding the response and clearing the valid bits.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_XL    = 3'd1,
    ST_MREQ  = 3'd2,
    ST_MWAIT = 3'd3,
    ST_RESP  = 3'd4
  } vipt_state_e;
endpackage

// File: rtl/vipt_tag_store.sv
// Per-line valid bit and physical tag, registered read.
module vipt_tag_store #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 20,
  localparam int LINES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [LINES-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      rd_vld <= 1'b0;
    end else begin
      if (wr_en) vld_q[wr_idx] <= 1'b1;
      if (rd_en) rd_vld <= vld_q[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
    if (rd_en) rd_tag <= tag_q[rd_idx];
  end
endmodule

// File: rtl/vipt_line_store.sv
// Line data, registered read, no reset.
module vipt_line_store #(
  parameter int IDX_W  = 6,
  parameter int LINE_W = 512,
  localparam int LINES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line
);
  logic [LINE_W-1:0] mem_q [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_line;
    if (rd_en) rd_line <= mem_q[rd_idx];
  end
endmodule

// File: rtl/vipt_word_sel.sv
// Picks one word of a line; word 0 sits in the low bits.
module vipt_word_sel #(
  parameter int LINE_W = 512,
  parameter int WORD_W = 32,
  localparam int WORDS = LINE_W / WORD_W,
  localparam int SEL_W = $clog2(WORDS)
) (
  input  logic [LINE_W-1:0] line,
  input  logic [SEL_W-1:0]  sel,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign words[w] = line[w*WORD_W +: WORD_W];
  end

  assign word = words[sel];
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_OFF_W = 12,
  parameter int LINES      = 64,
  parameter int LINE_BYTES = 64,
  parameter int WORD_W     = 32,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int IDX_W   = $clog2(LINES),
  localparam int VPN_W   = VA_W - PAGE_OFF_W,
  localparam int PPN_W   = PA_W - PAGE_OFF_W,
  localparam int LADDR_W = PA_W - OFF_W,
  localparam int LINE_W  = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic              xl_req,
  output logic [VPN_W-1:0]  xl_vpn,
  input  logic              xl_valid,
  input  logic              xl_miss,
  input  logic [PPN_W-1:0]  xl_ppn,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [LADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [LINE_W-1:0] mem_rsp_data
);
  import vipt_pkg::*;

  localparam int BYTE_SEL_W = $clog2(WORD_W / 8);
  localparam int SEL_W      = OFF_W - BYTE_SEL_W;

  vipt_state_e state_q, state_d;

  logic [PAGE_OFF_W-1:0] poff_q;
  logic [PPN_W-1:0]      ppn_q;
  logic [WORD_W-1:0]     rsp_data_q;
  logic                  rsp_hit_q;

  logic                  accept;
  logic                  xl_ok;
  logic                  tag_match;
  logic                  refill;
  logic [IDX_W-1:0]      rd_idx;
  logic [IDX_W-1:0]      line_idx;
  logic [SEL_W-1:0]      word_sel;
  logic                  rd_vld;
  logic [PPN_W-1:0]      rd_tag;
  logic [LINE_W-1:0]     rd_line;
  logic [WORD_W-1:0]     hit_word;
  logic [WORD_W-1:0]     fill_word;

  // Index straight from the virtual address; it lies inside the page offset.
  assign accept   = req_valid && (state_q == ST_IDLE);
  assign rd_idx   = req_vaddr[OFF_W +: IDX_W];
  assign line_idx = poff_q[OFF_W +: IDX_W];
  assign word_sel = poff_q[BYTE_SEL_W +: SEL_W];

  assign xl_ok     = xl_valid && !xl_miss;
  assign tag_match = rd_vld && (rd_tag == xl_ppn);
  assign refill    = (state_q == ST_MWAIT) && mem_rsp_valid;

  vipt_tag_store #(
    .IDX_W (IDX_W),
    .TAG_W (PPN_W)
  ) u_tags (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (accept),
    .rd_idx (rd_idx),
    .rd_vld (rd_vld),
    .rd_tag (rd_tag),
    .wr_en  (refill),
    .wr_idx (line_idx),
    .wr_tag (ppn_q)
  );

  vipt_line_store #(
    .IDX_W  (IDX_W),
    .LINE_W (LINE_W)
  ) u_lines (
    .clk     (clk),
    .rd_en   (accept),
    .rd_idx  (rd_idx),
    .rd_line (rd_line),
    .wr_en   (refill),
    .wr_idx  (line_idx),
    .wr_line (mem_rsp_data)
  );

  vipt_word_sel #(
    .LINE_W (LINE_W),
    .WORD_W (WORD_W)
  ) u_sel_hit (
    .line (rd_line),
    .sel  (word_sel),
    .word (hit_word)
  );

  vipt_word_sel #(
    .LINE_W (LINE_W),
    .WORD_W (WORD_W)
  ) u_sel_fill (
    .line (mem_rsp_data),
    .sel  (word_sel),
    .word (fill_word)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_XL;
      ST_XL:    if (xl_ok) state_d = tag_match ? ST_RESP : ST_MREQ;
      ST_MREQ:  if (mem_req_ready) state_d = ST_MWAIT;
      ST_MWAIT: if (mem_rsp_valid) state_d = ST_RESP;
      ST_RESP:  if (rsp_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      poff_q     <= '0;
      ppn_q      <= '0;
      rsp_data_q <= '0;
      rsp_hit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) poff_q <= req_vaddr[PAGE_OFF_W-1:0];
      if (state_q == ST_XL && xl_ok) begin
        ppn_q <= xl_ppn;
        if (tag_match) begin
          rsp_data_q <= hit_word;
          rsp_hit_q  <= 1'b1;
        end
      end
      if (refill) begin
        rsp_data_q <= fill_word;
        rsp_hit_q  <= 1'b0;
      end
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign xl_req        = accept;
  assign xl_vpn        = req_vaddr[VA_W-1:PAGE_OFF_W];
  assign mem_req_valid = (state_q == ST_MREQ);
  assign mem_req_addr  = {ppn_q, poff_q[PAGE_OFF_W-1:OFF_W]};
  assign mem_rsp_ready = (state_q == ST_MWAIT);
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_data      = rsp_data_q;
  assign rsp_hit       = rsp_hit_q;
endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk #(
  parameter int WORD_W  = 32,
  parameter int LADDR_W = 26
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_ready,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [WORD_W-1:0]   rsp_data,
  input logic                rsp_hit,
  input logic                xl_req,
  input logic                xl_valid,
  input logic                xl_miss,
  input logic                mem_req_valid,
  input logic                mem_req_ready,
  input logic [LADDR_W-1:0]  mem_req_addr,
  input logic                mem_rsp_valid,
  input logic                mem_rsp_ready,
  input vipt_pkg::vipt_state_e st
);
  import vipt_pkg::*;

  // R6
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> !req_ready);

  // R6
  busy_while_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_hit)));

  // R5
  xl_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_XL && !(xl_valid && !xl_miss)) |=> (st == ST_XL && !rsp_valid && !mem_req_valid));

  // R4
  refill_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R4
  refill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && mem_rsp_ready) |=> (rsp_valid && !rsp_hit));

  // R3
  hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> !mem_req_valid);
endmodule

bind vipt_cache vipt_cache_chk #(
  .WORD_W  (WORD_W),
  .LADDR_W (LADDR_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_data      (rsp_data),
  .rsp_hit       (rsp_hit),
  .xl_req        (xl_req),
  .xl_valid      (xl_valid),
  .xl_miss       (xl_miss),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_ready (mem_rsp_ready),
  .st            (state_q)
);

// File: tb/vipt_cache_bench.sv
module vipt_cache_bench;
  localparam int VA_W = 32, PA_W = 32, PO_W = 12;
  localparam int VPN_W = 20, PPN_W = 20, LADDR_W = 26, LINE_W = 512;
  localparam int NV = 9;
  // row: vpn(20) idx(6) word(4) hit(1) xl_lat(4) mem_lat(4)
  localparam logic [38:0] VECS [NV] = '{
    {20'd0, 6'd5, 4'd3,  1'b0, 4'd1, 4'd1},
    {20'd0, 6'd5, 4'd7,  1'b1, 4'd2, 4'd1},
    {20'd2, 6'd5, 4'd1,  1'b1, 4'd1, 4'd1},
    {20'd1, 6'd5, 4'd0,  1'b0, 4'd3, 4'd2},
    {20'd0, 6'd5, 4'd3,  1'b0, 4'd1, 4'd3},
    {20'd3, 6'd9, 4'd15, 1'b0, 4'd1, 4'd1},
    {20'd3, 6'd9, 4'd0,  1'b1, 4'd4, 4'd1},
    {20'd1, 6'd6, 4'd2,  1'b0, 4'd1, 4'd2},
    {20'd0, 6'd5, 4'd3,  1'b1, 4'd1, 4'd1}
  };
  // R1 cold, R3 warm, R8 alias, R10 evict, R10 evict back, R4, R5 long walk, R4, R3
  localparam string ROW_REQ [NV] = '{"R1", "R3", "R8", "R10", "R10", "R4", "R5", "R4", "R3"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [VA_W-1:0] req_vaddr = '0;
  logic rsp_valid, rsp_ready = 1'b0, rsp_hit;
  logic [31:0] rsp_data;
  logic xl_req, xl_valid = 1'b0, xl_miss = 1'b0;
  logic [VPN_W-1:0] xl_vpn;
  logic [PPN_W-1:0] xl_ppn = '0;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [LADDR_W-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0, mem_rsp_ready;
  logic [LINE_W-1:0] mem_rsp_data = '0;

  always #4 clk = ~clk;

  vipt_cache u_vipt_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
    .xl_req(xl_req), .xl_vpn(xl_vpn), .xl_valid(xl_valid), .xl_miss(xl_miss), .xl_ppn(xl_ppn),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0, n_fail = 0;
  logic [PPN_W-1:0] ppn_map [16];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [LINE_W-1:0] line_of(input logic [LADDR_W-1:0] a);
    logic [LINE_W-1:0] l;
    for (int w = 0; w < 16; w++) l[w*32 +: 32] = {2'b01, a, w[3:0]};
    return l;
  endfunction

  // translation unit model
  int xl_lat = 1, xl_cnt = 0, stall_viol = 0;
  bit xl_pend = 1'b0;
  logic [VPN_W-1:0] xl_vq = '0;
  always @(negedge clk) begin
    xl_valid = 1'b0;
    xl_miss  = 1'b0;
    if (!rst_n) xl_pend = 1'b0;
    else if (xl_pend) begin
      xl_cnt--;
      if (xl_cnt == 0) begin
        xl_valid = 1'b1;
        xl_ppn   = ppn_map[xl_vq[3:0]];
        xl_pend  = 1'b0;
      end else begin
        xl_miss = 1'b1;
        if (mem_req_valid || rsp_valid || req_ready) stall_viol++;
      end
    end else if (xl_req) begin
      xl_pend = 1'b1;
      xl_cnt  = xl_lat;
      xl_vq   = xl_vpn;
    end
  end

  // memory model
  int mem_lat = 1, m_cnt = 0, mem_cnt = 0;
  bit m_pend = 1'b0;
  logic [LADDR_W-1:0] m_addr = '0;
  always @(negedge clk) begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    if (!rst_n) m_pend = 1'b0;
    else if (m_pend) begin
      m_cnt--;
      if (m_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = line_of(m_addr);
        m_pend = 1'b0;
      end
    end else if (mem_req_valid) begin
      mem_req_ready = 1'b1;
      m_addr = mem_req_addr;
      m_pend = 1'b1;
      m_cnt  = mem_lat;
      mem_cnt++;
    end
  end

  task automatic access(input logic [VPN_W-1:0] vpn, input logic [5:0] idx,
                        input logic [3:0] wd, input bit exp_hit, input int xl,
                        input int ml, input int hold, input string rq);
    logic [VA_W-1:0] va;
    logic [LADDR_W-1:0] exp_la;
    logic [31:0] exp_d;
    int m0, n;
    bit busy_ok;
    va = {vpn, idx, wd, 2'b00};
    exp_la = {ppn_map[vpn[3:0]], idx};
    exp_d  = {2'b01, exp_la, wd};
    xl_lat = xl; mem_lat = ml; stall_viol = 0; m0 = mem_cnt;
    @(posedge clk); #2;
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    // R2: translation issued in the accept cycle
    chk(req_ready && xl_req && xl_vpn == vpn, "R2", "xl_req/xl_vpn",
        {req_ready, xl_req, 10'd0, xl_vpn}, {1'b1, 1'b1, 10'd0, vpn});
    @(posedge clk); #2;
    req_valid = 1'b0;
    n = 0; busy_ok = 1'b1;
    do begin
      @(negedge clk);
      if (req_ready) busy_ok = 1'b0;
      n++;
    end while (!rsp_valid && n < 200);
    chk(rsp_valid, "R6", "response arrives", 64'(rsp_valid), 64'd1);
    chk(busy_ok, "R6", "req_ready low while outstanding", 64'(busy_ok), 64'd1);
    chk(rsp_hit == exp_hit, rq, "rsp_hit", 64'(rsp_hit), 64'(exp_hit));
    chk(rsp_data == exp_d, "R9", "rsp_data word", 64'(rsp_data), 64'(exp_d));
    chk((mem_cnt - m0) == (exp_hit ? 0 : 1), exp_hit ? "R3" : "R4", "refill count",
        64'(mem_cnt - m0), exp_hit ? 64'd0 : 64'd1);
    if (!exp_hit) chk(m_addr == exp_la, "R4", "refill line address", 64'(m_addr), 64'(exp_la));
    chk(stall_viol == 0, "R5", "activity during translation wait", 64'(stall_viol), 64'd0);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == exp_d && rsp_hit == exp_hit, "R7", "held response",
          {31'd0, rsp_hit, rsp_data}, {31'd0, exp_hit, exp_d});
    end
    @(posedge clk); #2;
    rsp_ready = 1'b1;
    @(posedge clk); #2;
    rsp_ready = 1'b0;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R6", "idle after response",
        {62'd0, req_ready, rsp_valid}, 64'd2);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    chk(req_ready && !rsp_valid && !mem_req_valid && !xl_req, "R1", "reset outputs",
        {60'd0, req_ready, rsp_valid, mem_req_valid, xl_req}, 64'd8);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) ppn_map[i] = 20'h00040 + 20'(i);
    ppn_map[0] = 20'h00010;
    ppn_map[1] = 20'h00011;
    ppn_map[2] = 20'h00010;
    ppn_map[3] = 20'h00023;
    do_reset();
    for (int r = 0; r < NV; r++) begin
      access(VECS[r][38:19], VECS[r][18:13], VECS[r][12:9], VECS[r][8],
             int'(VECS[r][7:4]), int'(VECS[r][3:0]), 0, ROW_REQ[r]);
    end
    // R7: hold the response against a low rsp_ready
    access(20'd0, 6'd5, 4'd11, 1'b1, 1, 1, 3, "R7");
    // R8: remap virtual page 0 to a fresh physical page, no flush
    ppn_map[0] = 20'h00055;
    access(20'd0, 6'd5, 4'd3, 1'b0, 2, 1, 0, "R8");
    access(20'd0, 6'd5, 4'd4, 1'b1, 1, 1, 0, "R8");
    // R10: alternating physical lines on one index
    access(20'd1, 6'd5, 4'd4, 1'b0, 1, 1, 0, "R10");
    access(20'd0, 6'd5, 4'd4, 1'b0, 1, 1, 0, "R10");
    // R1: reset clears the valid bits
    do_reset();
    access(20'd0, 6'd5, 4'd4, 1'b0, 1, 1, 0, "R1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule